// File: doc/BRIEF.md
# Debug-to-CPU Mailbox

This block passes single words between an external debug port and an on-chip CPU or security agent, in both directions. Each direction has one data word, a set of generic flag bits and a full/empty indication. In the transmit direction the debug port loads the word and the CPU takes it. In the receive direction the CPU loads the word and the debug port takes it. Each direction is a two-state channel machine with states `SLOT_EMPTY` and `SLOT_FULL`. A load moves `SLOT_EMPTY` to `SLOT_FULL` (LOAD), or keeps `SLOT_FULL` with new data (RELOAD). A take with no load in the same cycle moves `SLOT_FULL` to `SLOT_EMPTY` (DRAIN).

While the transmit word is held, the block requests service from one of two handlers. The low byte of the word is the command byte and picks the handler. The block also raises a system reset request once after each full reset, driven by a three-state machine. It starts in `ONCE_ARMED`. The first transmit load moves it to `ONCE_FIRE` (TRIGGER), where the request is high for one cycle. It then moves to `ONCE_SPENT` (RETIRE) and stays there until the next reset. Event pulses for a landed transmit word and for a taken receive word go to an interrupt unit outside the block.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both data words and both status words read zero, both channels are empty, and `req_secmgr`, `req_owner`, `sysrst_req` and both event outputs are low.
- R2: A debug transmit load (`dbg_txd_we`) puts its word on `cpu_txd_rdata` and sets `tx_status` bit 0 in the next cycle. `evt_msg_pend` is high for exactly that one cycle.
- R3: A CPU take (`cpu_txd_rdata` read, signalled by `cpu_txd_re`) with no load in the same cycle clears `tx_status` bit 0 in the next cycle. Both request outputs drop in that same cycle. A take while empty changes nothing.
- R4: A transmit load while full replaces the word and keeps bit 0 set. A load and a take in the same cycle leave the channel full with the new word.
- R5: `tx_status` bits 31:1 show the last value written by the debug side through `dbg_txflag_we`. These bits are independent of data loads and takes, and the CPU has no way to write them.
- R6: While the transmit channel is full, exactly one request output is high; while it is empty, neither is. Bits 7:0 of the held word select the handler. A value of 0xAA selects `req_secmgr` when HAS_SECMGR is 1, and `req_owner` otherwise. A value of 0x55, or any other value, selects `req_owner`.
- R7: The first transmit data load after reset raises `sysrst_req` for exactly one cycle, in the cycle after the load. Later loads and flag writes do not raise it. A new reset arms it again.
- R8: A CPU receive load (`cpu_rxd_we`) puts its word on `dbg_rxd_rdata` and sets `rx_status` bit 0 in the next cycle. A debug take (`dbg_rxd_re`) while full clears bit 0 and pulses `evt_msg_taken` for one cycle. A take while empty does neither.
- R9: `rx_status` bits 31:1 show the last value the CPU wrote through `cpu_rxflag_we`. These bits are not disturbed by receive loads or takes.
- R10: A CPU receive load in the same cycle as a debug take leaves the receive channel full with the new word, and still pulses `evt_msg_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_txd_we | input | 1 | Debug side loads the transmit word |
| dbg_txd_wdata | input | 32 | Transmit word from debug side |
| dbg_txflag_we | input | 1 | Debug side writes transmit flags |
| dbg_txflag_wdata | input | 31 | Transmit flag value |
| dbg_rxd_re | input | 1 | Debug side takes the receive word |
| cpu_txd_re | input | 1 | CPU takes the transmit word |
| cpu_rxd_we | input | 1 | CPU loads the receive word |
| cpu_rxd_wdata | input | 32 | Receive word from CPU |
| cpu_rxflag_we | input | 1 | CPU writes receive flags |
| cpu_rxflag_wdata | input | 31 | Receive flag value |
| cpu_txd_rdata | output | 32 | Held transmit word |
| tx_status | output | 32 | Transmit flags in bits 31:1, full in bit 0 |
| dbg_rxd_rdata | output | 32 | Held receive word |
| rx_status | output | 32 | Receive flags in bits 31:1, full in bit 0 |
| req_secmgr | output | 1 | Service request to the security manager |
| req_owner | output | 1 | Service request to the owner handler |
| sysrst_req | output | 1 | One-cycle system reset request |
| evt_msg_pend | output | 1 | Transmit word landed (one-cycle pulse) |
| evt_msg_taken | output | 1 | Receive word taken (one-cycle pulse) |

## Verification
The bench checks a load that collides with a take in the same cycle, in both directions. If the design let the take win, the channel would show empty while holding a fresh word. It also reloads a full transmit channel with a different command byte. A router that latched its choice at the first load would then keep requesting the wrong handler. The bench sends flag writes before the first data load, later loads, and a second reset. A reset-once machine that is triggered by any write, or is never re-armed, would show up as a missing or extra `sysrst_req` pulse. Takes while empty confirm that no spurious taken event and no status change appear.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        ONCE_ARMED = 2'd0,
        ONCE_FIRE  = 2'd1,
        ONCE_SPENT = 2'd2
    } once_state_e;

    typedef enum logic [1:0] {
        ROUTE_NONE  = 2'd0,
        ROUTE_SEC   = 2'd1,
        ROUTE_OWNER = 2'd2
    } route_e;

    localparam int CMD_W = 8;
endpackage

// File: rtl/mb_slot.sv
module mb_slot
    import dbgmb_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int FLAG_W       = DATA_W - 1,
    parameter bit EVT_ON_WRITE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic              full,
    output logic              evt
);
    slot_state_e state_q, state_d;
    logic        evt_src;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: LOAD, RELOAD, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (wr_en) state_d = SLOT_FULL;
            SLOT_FULL:  if (!wr_en && rd_en) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            flags_q <= '0;
            evt     <= 1'b0;
        end else begin
            if (wr_en)   data_q  <= wr_data;
            if (flag_we) flags_q <= flag_wdata;
            evt <= evt_src;
        end
    end

    generate
        if (EVT_ON_WRITE) begin : g_evt_load
            assign evt_src = wr_en;
        end else begin : g_evt_take
            assign evt_src = rd_en && (state_q == SLOT_FULL);
        end
    endgenerate

    assign full = (state_q == SLOT_FULL);

    // R2
    load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full);
    // R3
    drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> !full);
    // R4
    load_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (data_q == $past(wr_data)));
    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags_q));
endmodule

// File: rtl/mb_once.sv
module mb_once
    import dbgmb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    once_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ONCE_ARMED;
        else        state_q <= state_d;
    end

    // transitions: TRIGGER, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ONCE_ARMED: if (trig) state_d = ONCE_FIRE;
            ONCE_FIRE:  state_d = ONCE_SPENT;
            ONCE_SPENT: state_d = ONCE_SPENT;
            default:    state_d = ONCE_SPENT;
        endcase
    end

    always_comb begin
        pulse = (state_q == ONCE_FIRE);
    end

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(trig));
endmodule

// File: rtl/mb_router.sv
module mb_router
    import dbgmb_pkg::*;
#(
    parameter bit              HAS_SECMGR = 1'b1,
    parameter logic [CMD_W-1:0] CMD_SEC   = 8'hAA,
    parameter logic [CMD_W-1:0] CMD_OWN   = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             full,
    input  logic [CMD_W-1:0] cmd,
    output logic             req_sec,
    output logic             req_own
);
    route_e route;

    always_comb begin
        if (!full)
            route = ROUTE_NONE;
        else if (cmd == CMD_SEC && HAS_SECMGR)
            route = ROUTE_SEC;
        else if (cmd == CMD_OWN)
            route = ROUTE_OWNER;
        else
            route = ROUTE_OWNER;
    end

    always_comb begin
        req_sec = 1'b0;
        req_own = 1'b0;
        unique case (route)
            ROUTE_SEC:   req_sec = 1'b1;
            ROUTE_OWNER: req_own = 1'b1;
            default:     ;
        endcase
    end

    // R6
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_sec, req_own}) && (full == (req_sec || req_own)));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbgmb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit HAS_SECMGR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_txd_we,
    input  logic [DATA_W-1:0] dbg_txd_wdata,
    input  logic              dbg_txflag_we,
    input  logic [DATA_W-2:0] dbg_txflag_wdata,
    input  logic              dbg_rxd_re,
    input  logic              cpu_txd_re,
    input  logic              cpu_rxd_we,
    input  logic [DATA_W-1:0] cpu_rxd_wdata,
    input  logic              cpu_rxflag_we,
    input  logic [DATA_W-2:0] cpu_rxflag_wdata,
    output logic [DATA_W-1:0] cpu_txd_rdata,
    output logic [DATA_W-1:0] tx_status,
    output logic [DATA_W-1:0] dbg_rxd_rdata,
    output logic [DATA_W-1:0] rx_status,
    output logic              req_secmgr,
    output logic              req_owner,
    output logic              sysrst_req,
    output logic              evt_msg_pend,
    output logic              evt_msg_taken
);
    localparam int FLAG_W = DATA_W - 1;

    logic [FLAG_W-1:0] tx_flags, rx_flags;
    logic              tx_full, rx_full;

    mb_slot #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .EVT_ON_WRITE(1'b1)) tx_slot_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dbg_txd_we), .wr_data(dbg_txd_wdata), .rd_en(cpu_txd_re),
        .flag_we(dbg_txflag_we), .flag_wdata(dbg_txflag_wdata),
        .data_q(cpu_txd_rdata), .flags_q(tx_flags), .full(tx_full),
        .evt(evt_msg_pend)
    );

    mb_slot #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .EVT_ON_WRITE(1'b0)) rx_slot_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cpu_rxd_we), .wr_data(cpu_rxd_wdata), .rd_en(dbg_rxd_re),
        .flag_we(cpu_rxflag_we), .flag_wdata(cpu_rxflag_wdata),
        .data_q(dbg_rxd_rdata), .flags_q(rx_flags), .full(rx_full),
        .evt(evt_msg_taken)
    );

    mb_router #(.HAS_SECMGR(HAS_SECMGR)) router_i (
        .clk(clk), .rst_n(rst_n),
        .full(tx_full), .cmd(cpu_txd_rdata[CMD_W-1:0]),
        .req_sec(req_secmgr), .req_own(req_owner)
    );

    mb_once once_i (
        .clk(clk), .rst_n(rst_n), .trig(dbg_txd_we), .pulse(sysrst_req)
    );

    assign tx_status = {tx_flags, tx_full};
    assign rx_status = {rx_flags, rx_full};

    // R8
    taken_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rxd_re && !rx_full) |=> !evt_msg_taken);
    // R10
    rx_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rxd_we && dbg_rxd_re && rx_full) |=> (rx_status[0] && evt_msg_taken));
endmodule

// File: tb/dbg_mailbox_tb_top.sv
module dbg_mailbox_tb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbg_txd_we = 0, dbg_txflag_we = 0, dbg_rxd_re = 0;
    logic cpu_txd_re = 0, cpu_rxd_we = 0, cpu_rxflag_we = 0;
    logic [31:0] dbg_txd_wdata = '0, cpu_rxd_wdata = '0;
    logic [30:0] dbg_txflag_wdata = '0, cpu_rxflag_wdata = '0;
    logic [31:0] cpu_txd_rdata, tx_status, dbg_rxd_rdata, rx_status;
    logic req_secmgr, req_owner, sysrst_req, evt_msg_pend, evt_msg_taken;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_txd, m_rxd;
    logic [30:0] m_txf, m_rxf;
    bit m_txfull, m_rxfull, m_armed, m_rst, m_pend, m_taken;

    always #(CLK_P/2) clk = ~clk;

    dbg_mailbox #(.DATA_W(32), .HAS_SECMGR(1'b1)) dut_i (.*);

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_txd = '0; m_rxd = '0; m_txf = '0; m_rxf = '0;
        m_txfull = 0; m_rxfull = 0; m_armed = 1; m_rst = 0; m_pend = 0; m_taken = 0;
    endtask

    task automatic model_step();
        bit old_rxfull;
        old_rxfull = m_rxfull;
        m_rst   = m_armed && dbg_txd_we;
        if (dbg_txd_we) m_armed = 0;
        m_pend  = dbg_txd_we;
        m_taken = dbg_rxd_re && old_rxfull;
        if (dbg_txd_we) begin m_txd = dbg_txd_wdata; m_txfull = 1; end
        else if (cpu_txd_re) m_txfull = 0;
        if (dbg_txflag_we) m_txf = dbg_txflag_wdata;
        if (cpu_rxd_we) begin m_rxd = cpu_rxd_wdata; m_rxfull = 1; end
        else if (dbg_rxd_re) m_rxfull = 0;
        if (cpu_rxflag_we) m_rxf = cpu_rxflag_wdata;
    endtask

    task automatic tick();
        bit es, eo;
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        @(negedge clk);
        es = m_txfull && (m_txd[7:0] == 8'hAA);
        eo = m_txfull && !es;
        chk("R2", cpu_txd_rdata, m_txd);
        chk("R5", tx_status, {m_txf, m_txfull});
        chk("R6", {30'd0, req_secmgr, req_owner}, {30'd0, es, eo});
        chk("R7", {31'd0, sysrst_req}, {31'd0, m_rst});
        chk("R2", {31'd0, evt_msg_pend}, {31'd0, m_pend});
        chk("R8", dbg_rxd_rdata, m_rxd);
        chk("R9", rx_status, {m_rxf, m_rxfull});
        chk("R8", {31'd0, evt_msg_taken}, {31'd0, m_taken});
    endtask

    task automatic idle();
        dbg_txd_we = 0; dbg_txflag_we = 0; dbg_rxd_re = 0;
        cpu_txd_re = 0; cpu_rxd_we = 0; cpu_rxflag_we = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; idle();
        repeat (3) tick();
        rst_n = 1;
    endtask

    task automatic tx_load(input logic [31:0] d);
        dbg_txd_we = 1; dbg_txd_wdata = d; tick(); idle();
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1 reset state
        chk("R1", cpu_txd_rdata | tx_status | dbg_rxd_rdata | rx_status, 32'h0);
        chk("R1", {27'd0, req_secmgr, req_owner, sysrst_req, evt_msg_pend, evt_msg_taken}, 32'h0);
        tick();

        // R5/R7 flag write before any data load: no reset request
        dbg_txflag_we = 1; dbg_txflag_wdata = 31'h1234_5678; tick(); idle();
        chk("R5", tx_status, {31'h1234_5678, 1'b0});
        chk("R7", {31'd0, sysrst_req}, 32'h0);

        // R2/R6/R7 first load with security command
        tx_load(32'hCAFE_01AA);
        chk("R7", {31'd0, sysrst_req}, 32'h1);
        chk("R6", {30'd0, req_secmgr, req_owner}, 32'h2);
        tick();
        chk("R7", {31'd0, sysrst_req}, 32'h0);

        // R3 take empties and drops request
        cpu_txd_re = 1; tick(); idle();
        chk("R3", {30'd0, req_secmgr, req_owner}, 32'h0);
        chk("R3", tx_status, {31'h1234_5678, 1'b0});
        cpu_txd_re = 1; tick(); idle();
        chk("R3", cpu_txd_rdata, 32'hCAFE_01AA);

        // R6 owner command, R7 no second pulse
        tx_load(32'h0000_0055);
        chk("R6", {30'd0, req_secmgr, req_owner}, 32'h1);
        chk("R7", {31'd0, sysrst_req}, 32'h0);
        // R4 reload while full switches route
        tx_load(32'h0000_11AA);
        chk("R4", tx_status[0], 1'b1);
        chk("R4", {30'd0, req_secmgr, req_owner}, 32'h2);
        // R4 load and take together
        dbg_txd_we = 1; dbg_txd_wdata = 32'hBEEF_0042; cpu_txd_re = 1; tick(); idle();
        chk("R4", cpu_txd_rdata, 32'hBEEF_0042);
        chk("R6", {30'd0, req_secmgr, req_owner}, 32'h1);
        cpu_txd_re = 1; tick(); idle();

        // R8/R9 receive direction
        dbg_rxd_re = 1; tick(); idle();
        chk("R8", {31'd0, evt_msg_taken}, 32'h0);
        cpu_rxflag_we = 1; cpu_rxflag_wdata = 31'h0ABC_DEF0; tick(); idle();
        cpu_rxd_we = 1; cpu_rxd_wdata = 32'h5A5A_0001; tick(); idle();
        chk("R9", rx_status, {31'h0ABC_DEF0, 1'b1});
        chk("R8", dbg_rxd_rdata, 32'h5A5A_0001);
        // R10 collision
        cpu_rxd_we = 1; cpu_rxd_wdata = 32'h5A5A_0002; dbg_rxd_re = 1; tick(); idle();
        chk("R10", rx_status[0], 1'b1);
        chk("R10", {31'd0, evt_msg_taken}, 32'h1);
        dbg_rxd_re = 1; tick(); idle();
        chk("R8", {31'd0, evt_msg_taken}, 32'h1);
        chk("R9", rx_status, {31'h0ABC_DEF0, 1'b0});
        tick();

        // R7 re-armed by reset
        do_reset();
        tick();
        tx_load(32'h0000_0001);
        chk("R7", {31'd0, sysrst_req}, 32'h1);
        tick();

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            dbg_txd_we    = r[0] & r[1];
            dbg_txd_wdata = {$urandom} ^ ((r[5:4] == 2'd0) ? 32'h0 : 32'h0);
            if (r[3:2] == 2'd1) dbg_txd_wdata[7:0] = 8'hAA;
            if (r[3:2] == 2'd2) dbg_txd_wdata[7:0] = 8'h55;
            dbg_txflag_we    = r[6] & r[7] & r[8];
            dbg_txflag_wdata = 31'($urandom);
            cpu_txd_re    = r[9];
            cpu_rxd_we    = r[10] & r[11];
            cpu_rxd_wdata = $urandom;
            cpu_rxflag_we = r[12] & r[13] & r[14];
            cpu_rxflag_wdata = 31'($urandom);
            dbg_rxd_re    = r[15];
            tick();
        end
        idle();
        tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule